// File: doc/BRIEF.md
# AXI Address Duty-Cycle and Word-Budget Throttle

This block sits on the read-address and write-address channels between an AXI manager and its subordinate. It admits new transactions only during a repeating open window, and it limits the data volume that each window period may start. A period is an open phase of `ON_CYCLES` cycles followed by a shut phase of `OFF_CYCLES` cycles, and the pattern repeats for as long as the block runs. During the shut phase no address handshake completes on either channel.

A word counter adds the beat count of every accepted address, read or write, where the beat count is the burst-length field plus one. It restarts in the first cycle of each open phase. The budget is tested only before a transaction. Once the counter has reached or passed `WORD_CAP`, both channels stay closed until the next period begins. An address that arrives below the cap is still admitted whole, even when its burst carries the total past the cap. A cap of zero turns the budget off. A shut phase of zero keeps the window open all the time, so only the budget applies.

Write data, read data and write response carry no addresses and are wired around the block. The block holds no storage beyond its phase counter and its word counter.

Top module: `axi_pulse_throttle`

## Requirements
- R1: While `rst` is high, no address passes in either direction: `s_ar_ready`, `s_aw_ready`, `m_ar_valid` and `m_aw_valid` are all 0. The first cycle after `rst` falls is cycle 0 of an open phase, with the word counter at zero.
- R2: In an open phase that has budget left, `m_ar_valid` follows `s_ar_valid` and `s_ar_ready` follows `m_ar_ready`. The write channel behaves the same way, subject to R9.
- R3: In cycles `ON_CYCLES` to `ON_CYCLES+OFF_CYCLES-1` of each period, `s_ar_ready`, `s_aw_ready`, `m_ar_valid` and `m_aw_valid` are all 0, whatever the inputs.
- R4: The period has a length of `ON_CYCLES+OFF_CYCLES` and repeats without end. Periods after the first show the same open and shut cycles as the first.
- R5: Each address handshake, read or write, adds its `len` field plus one to the word counter.
- R6: When a cycle is not the first cycle of a period and the counter is at or above `WORD_CAP`, no address handshake completes and both outgoing valids are 0.
- R7: An address that is presented while the counter is below `WORD_CAP` is admitted, even when `len+1` carries the counter past `WORD_CAP`.
- R8: The word counter restarts from zero in cycle 0 of every period. A period that follows an exhausted one accepts addresses again from its first cycle.
- R9: While `s_ar_valid` is 1 and the read channel is allowed, the write channel is held closed. A read address and a write address therefore never complete a handshake in the same cycle.
- R10: With `OFF_CYCLES` = 0, the gate never shuts, and only the budget of R6 limits traffic.
- R11: With `WORD_CAP` = 0, the budget never closes the gate, and only the window limits traffic.
- R12: While an outgoing valid is 1, the outgoing `id`, `addr` and `len` equal the incoming values on the same channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_ar_valid | input | 1 | Read address valid from manager |
| s_ar_ready | output | 1 | Read address ready to manager |
| s_ar_id | input | ID_W | Read ID from manager |
| s_ar_addr | input | ADDR_W | Read address from manager |
| s_ar_len | input | 8 | Read burst length minus one from manager |
| m_ar_valid | output | 1 | Read address valid to subordinate |
| m_ar_ready | input | 1 | Read address ready from subordinate |
| m_ar_id | output | ID_W | Read ID to subordinate |
| m_ar_addr | output | ADDR_W | Read address to subordinate |
| m_ar_len | output | 8 | Read burst length to subordinate |
| s_aw_valid | input | 1 | Write address valid from manager |
| s_aw_ready | output | 1 | Write address ready to manager |
| s_aw_id | input | ID_W | Write ID from manager |
| s_aw_addr | input | ADDR_W | Write address from manager |
| s_aw_len | input | 8 | Write burst length minus one from manager |
| m_aw_valid | output | 1 | Write address valid to subordinate |
| m_aw_ready | input | 1 | Write address ready from subordinate |
| m_aw_id | output | ID_W | Write ID to subordinate |
| m_aw_addr | output | ADDR_W | Write address to subordinate |
| m_aw_len | output | 8 | Write burst length to subordinate |

## Verification
The hardest case to reach is an overshoot: a burst that is admitted just below the cap and carries the counter past it. It must be followed by a closed gate for the rest of the period and by a fresh budget in the first cycle of the next one. This only happens when burst lengths, handshake timing and the period boundary line up. Directed opening cycles therefore push two long reads in quickly, one after the other, against a small cap, with a write waiting behind them. A seeded random phase then runs through many short periods on three instances: a standard one, one with no shut phase and one with no cap. A per-cycle bench model predicts every gate decision.

// File: rtl/apt_pkg.sv
package apt_pkg;

    localparam int AXLEN_W = 8;
    localparam int BEATS_W = AXLEN_W + 1;

    typedef logic [AXLEN_W-1:0] axlen_t;

    typedef enum logic {
        PH_SHUT = 1'b0,
        PH_OPEN = 1'b1
    } phase_e;

    // number of data words carried by a burst
    function automatic logic [BEATS_W-1:0] beats_of(input axlen_t len);
        return {1'b0, len} + BEATS_W'(1);
    endfunction

    // width of a counter that must hold values up to and including max_val
    function automatic int width_for(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/apt_window.sv
module apt_window
    import apt_pkg::*;
#(
    parameter int ON_CYCLES  = 5100,
    parameter int OFF_CYCLES = 5100
) (
    input  logic   clk,
    input  logic   rst,
    output phase_e phase,
    output logic   start
);
    localparam int PERIOD = ON_CYCLES + OFF_CYCLES;
    localparam int PH_W   = width_for(PERIOD);

    logic [PH_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst)                                pos_q <= '0;
        else if (pos_q == PH_W'(PERIOD - 1))   pos_q <= '0;
        else                                    pos_q <= pos_q + PH_W'(1);
    end

    assign start = (pos_q == '0);

    generate
        if (OFF_CYCLES == 0) begin : g_always_open
            assign phase = PH_OPEN;
        end else begin : g_duty
            assign phase = (pos_q < PH_W'(ON_CYCLES)) ? PH_OPEN : PH_SHUT;
        end
    endgenerate

    // R4: the position counter stays inside one period
    assert_period_bound_R4: assert property (@(posedge clk) disable iff (rst)
        pos_q < PH_W'(PERIOD));

endmodule

// File: rtl/apt_budget.sv
module apt_budget
    import apt_pkg::*;
#(
    parameter int WORD_CAP = 625
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   ar_take,
    input  axlen_t ar_len,
    input  logic   aw_take,
    input  axlen_t aw_len,
    output logic   under
);
    localparam int CNT_W = width_for(WORD_CAP + 2 * (1 << AXLEN_W));

    logic [CNT_W-1:0] cnt_q, cnt_eff, cnt_d;

    always_comb begin
        cnt_eff = start ? '0 : cnt_q;
        cnt_d   = cnt_eff;
        if (ar_take) cnt_d = cnt_d + CNT_W'(beats_of(ar_len));
        if (aw_take) cnt_d = cnt_d + CNT_W'(beats_of(aw_len));
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign under = (WORD_CAP == 0) || (cnt_eff < CNT_W'(WORD_CAP));

    // R6: an exhausted budget admits nothing
    assert_cap_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        !under |-> (!ar_take && !aw_take));

    // R8: the counter restarts at a period boundary
    assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (start && !ar_take && !aw_take) |=> (cnt_q == '0));

endmodule

// File: rtl/apt_gate.sv
module apt_gate
    import apt_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int ADDR_W = 32
) (
    input  logic              allow,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [ID_W-1:0]   s_id,
    input  logic [ADDR_W-1:0] s_addr,
    input  axlen_t            s_len,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [ID_W-1:0]   m_id,
    output logic [ADDR_W-1:0] m_addr,
    output axlen_t            m_len,
    output logic              take
);
    assign m_valid = s_valid & allow;
    assign s_ready = m_ready & allow;
    assign m_id    = s_id;
    assign m_addr  = s_addr;
    assign m_len   = s_len;
    assign take    = s_valid & m_ready & allow;
endmodule

// File: rtl/axi_pulse_throttle.sv
module axi_pulse_throttle
    import apt_pkg::*;
#(
    parameter int ON_CYCLES  = 5100,
    parameter int OFF_CYCLES = 5100,
    parameter int WORD_CAP   = 625,
    parameter int ID_W       = 4,
    parameter int ADDR_W     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_ar_valid,
    output logic              s_ar_ready,
    input  logic [ID_W-1:0]   s_ar_id,
    input  logic [ADDR_W-1:0] s_ar_addr,
    input  logic [7:0]        s_ar_len,
    output logic              m_ar_valid,
    input  logic              m_ar_ready,
    output logic [ID_W-1:0]   m_ar_id,
    output logic [ADDR_W-1:0] m_ar_addr,
    output logic [7:0]        m_ar_len,
    input  logic              s_aw_valid,
    output logic              s_aw_ready,
    input  logic [ID_W-1:0]   s_aw_id,
    input  logic [ADDR_W-1:0] s_aw_addr,
    input  logic [7:0]        s_aw_len,
    output logic              m_aw_valid,
    input  logic              m_aw_ready,
    output logic [ID_W-1:0]   m_aw_id,
    output logic [ADDR_W-1:0] m_aw_addr,
    output logic [7:0]        m_aw_len
);
    phase_e win_phase;
    logic   win_start;
    logic   budget_ok;
    logic   base_allow, ar_allow, aw_allow;
    logic   ar_take, aw_take;

    apt_window #(.ON_CYCLES(ON_CYCLES), .OFF_CYCLES(OFF_CYCLES)) u_window (
        .clk(clk), .rst(rst), .phase(win_phase), .start(win_start)
    );

    apt_budget #(.WORD_CAP(WORD_CAP)) u_budget (
        .clk(clk), .rst(rst), .start(win_start),
        .ar_take(ar_take), .ar_len(s_ar_len),
        .aw_take(aw_take), .aw_len(s_aw_len),
        .under(budget_ok)
    );

    // read has priority: a pending read closes the write channel this cycle
    assign base_allow = !rst && (win_phase == PH_OPEN) && budget_ok;
    assign ar_allow   = base_allow;
    assign aw_allow   = base_allow && !s_ar_valid;

    apt_gate #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_ar_gate (
        .allow(ar_allow), .s_valid(s_ar_valid), .s_ready(s_ar_ready),
        .s_id(s_ar_id), .s_addr(s_ar_addr), .s_len(s_ar_len),
        .m_valid(m_ar_valid), .m_ready(m_ar_ready),
        .m_id(m_ar_id), .m_addr(m_ar_addr), .m_len(m_ar_len), .take(ar_take)
    );

    apt_gate #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_aw_gate (
        .allow(aw_allow), .s_valid(s_aw_valid), .s_ready(s_aw_ready),
        .s_id(s_aw_id), .s_addr(s_aw_addr), .s_len(s_aw_len),
        .m_valid(m_aw_valid), .m_ready(m_aw_ready),
        .m_id(m_aw_id), .m_addr(m_aw_addr), .m_len(m_aw_len), .take(aw_take)
    );

    // R3: the shut phase closes both channels in both directions
    assert_shut_closed_R3: assert property (@(posedge clk) disable iff (rst)
        (win_phase == PH_SHUT) |-> (!m_ar_valid && !m_aw_valid && !s_ar_ready && !s_aw_ready));

    // R9: never two address handshakes in one cycle
    assert_one_handshake_R9: assert property (@(posedge clk) disable iff (rst)
        !((s_ar_valid && s_ar_ready) && (s_aw_valid && s_aw_ready)));

endmodule

// File: tb/sim_axi_pulse_throttle.sv
module sim_axi_pulse_throttle;

    localparam int NI = 3;
    localparam int ON_P  [NI] = '{20, 12, 9};
    localparam int OFF_P [NI] = '{10, 0, 7};
    localparam int CAP_P [NI] = '{24, 16, 0};
    localparam int RUN_CYCLES = 400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       ar_v, ar_rdy_in, aw_v, aw_rdy_in;
    logic [3:0] ar_id, aw_id;
    logic [31:0] ar_addr, aw_addr;
    logic [7:0] ar_len, aw_len;

    logic        o_ar_rdy [NI], o_ar_v [NI], o_aw_rdy [NI], o_aw_v [NI];
    logic [3:0]  o_ar_id [NI], o_aw_id [NI];
    logic [31:0] o_ar_addr [NI], o_aw_addr [NI];
    logic [7:0]  o_ar_len [NI], o_aw_len [NI];

    axi_pulse_throttle #(.ON_CYCLES(20), .OFF_CYCLES(10), .WORD_CAP(24)) u0 (
        .clk(clk), .rst(rst),
        .s_ar_valid(ar_v), .s_ar_ready(o_ar_rdy[0]), .s_ar_id(ar_id), .s_ar_addr(ar_addr), .s_ar_len(ar_len),
        .m_ar_valid(o_ar_v[0]), .m_ar_ready(ar_rdy_in), .m_ar_id(o_ar_id[0]), .m_ar_addr(o_ar_addr[0]), .m_ar_len(o_ar_len[0]),
        .s_aw_valid(aw_v), .s_aw_ready(o_aw_rdy[0]), .s_aw_id(aw_id), .s_aw_addr(aw_addr), .s_aw_len(aw_len),
        .m_aw_valid(o_aw_v[0]), .m_aw_ready(aw_rdy_in), .m_aw_id(o_aw_id[0]), .m_aw_addr(o_aw_addr[0]), .m_aw_len(o_aw_len[0]));

    axi_pulse_throttle #(.ON_CYCLES(12), .OFF_CYCLES(0), .WORD_CAP(16)) u1 (
        .clk(clk), .rst(rst),
        .s_ar_valid(ar_v), .s_ar_ready(o_ar_rdy[1]), .s_ar_id(ar_id), .s_ar_addr(ar_addr), .s_ar_len(ar_len),
        .m_ar_valid(o_ar_v[1]), .m_ar_ready(ar_rdy_in), .m_ar_id(o_ar_id[1]), .m_ar_addr(o_ar_addr[1]), .m_ar_len(o_ar_len[1]),
        .s_aw_valid(aw_v), .s_aw_ready(o_aw_rdy[1]), .s_aw_id(aw_id), .s_aw_addr(aw_addr), .s_aw_len(aw_len),
        .m_aw_valid(o_aw_v[1]), .m_aw_ready(aw_rdy_in), .m_aw_id(o_aw_id[1]), .m_aw_addr(o_aw_addr[1]), .m_aw_len(o_aw_len[1]));

    axi_pulse_throttle #(.ON_CYCLES(9), .OFF_CYCLES(7), .WORD_CAP(0)) u2 (
        .clk(clk), .rst(rst),
        .s_ar_valid(ar_v), .s_ar_ready(o_ar_rdy[2]), .s_ar_id(ar_id), .s_ar_addr(ar_addr), .s_ar_len(ar_len),
        .m_ar_valid(o_ar_v[2]), .m_ar_ready(ar_rdy_in), .m_ar_id(o_ar_id[2]), .m_ar_addr(o_ar_addr[2]), .m_ar_len(o_ar_len[2]),
        .s_aw_valid(aw_v), .s_aw_ready(o_aw_rdy[2]), .s_aw_id(aw_id), .s_aw_addr(aw_addr), .s_aw_len(aw_len),
        .m_aw_valid(o_aw_v[2]), .m_aw_ready(aw_rdy_in), .m_aw_id(o_aw_id[2]), .m_aw_addr(o_aw_addr[2]), .m_aw_len(o_aw_len[2]));

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int words [NI];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // requirement that governs a gate decision of the standard instance
    function automatic string tag_for(input int i, input int t, input bit open,
                                      input bit under, input int eff, input bit rd_ok);
        int per;
        int ln;
        per = ON_P[i] + OFF_P[i];
        ln  = ar_v ? int'(ar_len) : int'(aw_len);
        if (i == 1) return "R10";
        if (i == 2) return "R11";
        if (!open) return "R3";
        if ((t % per) == 0 && t >= per) return "R8";
        if (!under) return "R6 (R5 accounting)";
        if (eff > 0 && eff + ln + 1 > CAP_P[i]) return "R7";
        if (rd_ok && ar_v && aw_v) return "R9";
        if (t >= per) return "R4";
        return "R2";
    endfunction

    task automatic drive(input bit av, input int al, input bit wv, input int wl,
                         input bit ardy, input bit awdy);
        ar_v = av; ar_len = 8'(al); aw_v = wv; aw_len = 8'(wl);
        ar_rdy_in = ardy; aw_rdy_in = awdy;
        ar_id = 4'($urandom); aw_id = 4'($urandom);
        ar_addr = $urandom; aw_addr = $urandom;
    endtask

    task automatic step_check(input int t);
        for (int i = 0; i < NI; i++) begin
            int per, ph, eff;
            bit open, start, under, rd_ok, wr_ok;
            bit [3:0] exp_v, act_v;
            string tg;
            per   = ON_P[i] + OFF_P[i];
            ph    = t % per;
            open  = (OFF_P[i] == 0) || (ph < ON_P[i]);
            start = (ph == 0);
            eff   = start ? 0 : words[i];
            under = (CAP_P[i] == 0) || (eff < CAP_P[i]);
            rd_ok = open && under;
            wr_ok = rd_ok && !ar_v;
            exp_v = {ar_rdy_in && rd_ok, ar_v && rd_ok, aw_rdy_in && wr_ok, aw_v && wr_ok};
            act_v = {o_ar_rdy[i], o_ar_v[i], o_aw_rdy[i], o_aw_v[i]};
            tg = tag_for(i, t, open, under, eff, rd_ok);
            check(act_v === exp_v, tg, $sformatf("inst%0d cycle%0d {arrdy,arv,awrdy,awv}", i, t),
                  act_v, exp_v);
            if (o_ar_v[i])
                check({o_ar_id[i], o_ar_addr[i], o_ar_len[i]} === {ar_id, ar_addr, ar_len},
                      "R12", "ar payload", {o_ar_id[i], o_ar_addr[i], o_ar_len[i]}, {ar_id, ar_addr, ar_len});
            if (o_aw_v[i])
                check({o_aw_id[i], o_aw_addr[i], o_aw_len[i]} === {aw_id, aw_addr, aw_len},
                      "R12", "aw payload", {o_aw_id[i], o_aw_addr[i], o_aw_len[i]}, {aw_id, aw_addr, aw_len});
            // R5: every admitted address adds len+1 words
            words[i] = eff + ((ar_v && ar_rdy_in && rd_ok) ? int'(ar_len) + 1 : 0)
                           + ((aw_v && aw_rdy_in && wr_ok) ? int'(aw_len) + 1 : 0);
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd1234);
        drive(1, 3, 1, 3, 1, 1);
        repeat (3) @(negedge clk);
        // R1: reset holds every channel closed
        for (int i = 0; i < NI; i++)
            check({o_ar_rdy[i], o_ar_v[i], o_aw_rdy[i], o_aw_v[i]} === 4'b0, "R1",
                  $sformatf("inst%0d outputs in reset", i),
                  {o_ar_rdy[i], o_ar_v[i], o_aw_rdy[i], o_aw_v[i]}, 0);
        for (int i = 0; i < NI; i++) words[i] = 0;
        rst = 1'b0;
        for (int t = 0; t < RUN_CYCLES; t++) begin
            if (t == 0)      drive(1, 15, 1, 3, 1, 1);   // R1/R7: long read at cycle 0, write waits
            else if (t == 1) drive(1, 15, 1, 3, 1, 1);   // R7: second long read overshoots cap of u0
            else if (t == 2) drive(0, 0, 1, 0, 1, 1);    // R6: budget spent, write held
            else begin
                int al, wl;
                al = ($urandom % 8 == 0) ? 15 : int'($urandom % 8);
                wl = ($urandom % 8 == 0) ? 15 : int'($urandom % 8);
                drive(($urandom % 10) < 5, al, ($urandom % 10) < 6, wl,
                      ($urandom % 10) < 8, ($urandom % 10) < 8);
            end
            #1;
            step_check(t);
            @(negedge clk);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule